// File: doc/BRIEF.md
# Multicycle Fetch-Execute Controller

This block sequences a small 16-bit processor with four general registers and a 256-word memory. Every instruction follows the same path. The controller reads the word at the program counter over a synchronous memory port and latches it into the instruction register. It then advances the program counter, splits the word into its fields and executes it. Execution happens either inside the controller or through three external ports: an ALU port, a pair of valid/ready data ports for input and output, and a strobe port to an external call-stack engine. A `start` pulse begins a run. It clears the program counter, the status register and the tick ledger, and it latches the program size as the fetch limit.

Each instruction has a fixed cost in ticks that depends on its class. Memory-touching and stack instructions cost 4 ticks, data-port instructions cost 28, and all other instructions cost 1. The cost is added to the tick ledger when the instruction retires. Fetch has no separate cost. The wall-clock cycle count of an instruction may exceed its cost, for example while an output transfer waits for `io_out_ready`, but the ledger still grows by the fixed cost only. A halt instruction stops the machine. An undefined opcode, or a fetch at or beyond the limit, stops it and also raises `error`.

Top module: `fx_ctrl`

## Requirements
- R1: Word fields are: opcode in bits 15:11, destination register in bits 10:9, immediate flag in bit 8, source register in bits 7:6, and address/constant in bits 7:0. When the immediate flag is 1, the ALU second operand is the constant sign-extended to 16 bits. Otherwise it is the source register.
- R2: Each instruction begins with a memory read (`mem_rd`=1) at address `pc`. The program counter advances by exactly one in the cycle the fetched word is latched.
- R3: Opcode 0 with the immediate flag at 0 loads the destination register from memory at the unsigned 8-bit address. With the flag at 1, it loads the sign-extended constant and makes no memory access.
- R4: `tick_count` is cleared by `start`. At each retirement it grows by 4 for load-from-memory (opcode 0, flag 0), store (1), call (20) and return (21). It grows by 28 for read (22) and write (23), and by 1 for every other instruction. The cost does not change when a data port stalls.
- R5: Opcode 1 writes the destination register to memory at the 8-bit address.
- R6: Opcode 16 always loads `pc` with the address. Opcodes 17, 18 and 19 load it only when status bit 3 (less), bit 2 (equal) or bit 1 (greater) is 1, respectively.
- R7: Opcode 24 stops fetching and sets `halted`, which stays set until the next `start`. Opcode 25 changes nothing except the program counter.
- R8: Opcode 14 copies the status register into the destination register. Opcode 15 copies the destination register into the status register.
- R9: Opcodes 2 through 13 present the operands, the opcode and the current status to the ALU. The ALU result is written to the destination register for every opcode except 13 (compare). The ALU's next status is always taken.
- R10: Read (22) holds `io_in_ready` until one transfer and stores `io_in_data` in the destination register. Write (23) holds `io_out_valid` with stable data until one transfer.
- R11: Call (20) pulses `stk_push` with `stk_pc_out` equal to the return address and jumps to the address. Return (21) pulses `stk_pop` and loads `pc` from `stk_pc_in`. The two strobes are never active together.
- R12: Opcodes 26 to 31, or a fetch with `pc` at or above the latched limit, set `error` and `halted`. Such an event adds nothing to the tick ledger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start | input | 1 | Begin a run from address 0 (accepted when idle or halted) |
| limit | input | 9 | Program size in words, latched at start |
| mem_addr | output | 8 | Memory address |
| mem_rd | output | 1 | Memory read request; data valid the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| alu_opc | output | 5 | Opcode presented to the ALU |
| alu_a | output | 16 | First operand (destination register) |
| alu_b | output | 16 | Second operand (source register or extended constant) |
| alu_st | output | 16 | Current status register |
| alu_y | input | 16 | ALU result |
| alu_st_nx | input | 16 | ALU next status |
| io_in_valid | input | 1 | Input data valid |
| io_in_ready | output | 1 | Controller accepts input |
| io_in_data | input | 16 | Input data |
| io_out_valid | output | 1 | Output data valid |
| io_out_ready | input | 1 | Consumer accepts output |
| io_out_data | output | 16 | Output data |
| stk_push | output | 1 | Call strobe to stack engine |
| stk_pop | output | 1 | Return strobe to stack engine |
| stk_pc_out | output | 8 | Return address for a call |
| stk_pc_in | input | 8 | Restored program counter for a return |
| pc_o | output | 8 | Program counter |
| running | output | 1 | A run is in progress |
| halted | output | 1 | Execution stopped |
| error | output | 1 | Stopped on an illegal opcode or limit overrun |
| tick_count | output | 32 | Tick ledger |

## Verification
The embedded checks rely on three assumptions about the environment. The memory returns read data exactly one cycle after `mem_rd`. The stack engine presents a valid `stk_pc_in` whenever a return retires. `start` is pulsed only while the controller is idle or halted. The bench meets all three. Its memory model is a one-cycle synchronous array, and its stack model is a small array updated on the strobes. It asserts `start` only after observing `halted`. It holds `io_in_valid` high, and in one run it keeps `io_out_ready` low for a long stretch, so that stable output data and a stall-independent tick cost are both exercised.

// File: rtl/fx_pkg.sv
package fx_pkg;

  localparam logic [4:0] OP_LOAD  = 5'd0;
  localparam logic [4:0] OP_STORE = 5'd1;
  localparam logic [4:0] OP_ALU_LO = 5'd2;
  localparam logic [4:0] OP_CMP   = 5'd13;
  localparam logic [4:0] OP_GETST = 5'd14;
  localparam logic [4:0] OP_PUTST = 5'd15;
  localparam logic [4:0] OP_JMP   = 5'd16;
  localparam logic [4:0] OP_JLT   = 5'd17;
  localparam logic [4:0] OP_JEQ   = 5'd18;
  localparam logic [4:0] OP_JGT   = 5'd19;
  localparam logic [4:0] OP_CALL  = 5'd20;
  localparam logic [4:0] OP_RET   = 5'd21;
  localparam logic [4:0] OP_READ  = 5'd22;
  localparam logic [4:0] OP_WRITE = 5'd23;
  localparam logic [4:0] OP_HALT  = 5'd24;
  localparam logic [4:0] OP_NOOP  = 5'd25;

  // status bit positions
  localparam int ST_LT = 3;
  localparam int ST_EQ = 2;
  localparam int ST_GT = 1;

  typedef enum logic [1:0] {CL_INT, CL_MEM, CL_IO} lat_class_e;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LATCH, S_EXEC, S_STOP} seq_state_e;

endpackage

// File: rtl/fx_decode.sv
module fx_decode
  import fx_pkg::*;
#(
  parameter int DW = 16,
  parameter int RW = 2
) (
  input  logic [DW-1:0] ir,
  output logic [4:0]    opc,
  output logic [RW-1:0] rd,
  output logic [RW-1:0] rs,
  output logic          imm,
  output logic [7:0]    k8,
  output logic [DW-1:0] kx,
  output lat_class_e    cls,
  output logic          legal
);

  always_comb begin
    opc = ir[15:11];
    rd  = ir[10:9];
    imm = ir[8];
    rs  = ir[7:6];
    k8  = ir[7:0];
    kx  = {{(DW-8){ir[7]}}, ir[7:0]};
    legal = (opc <= OP_NOOP);
    cls = CL_INT;
    if ((opc == OP_LOAD && !imm) || opc == OP_STORE || opc == OP_CALL || opc == OP_RET)
      cls = CL_MEM;
    else if (opc == OP_READ || opc == OP_WRITE)
      cls = CL_IO;
  end

endmodule

// File: rtl/fx_regfile.sv
module fx_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [SW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [SW-1:0] sel_a,
  input  logic [SW-1:0] sel_b,
  output logic [DW-1:0] rd_a,
  output logic [DW-1:0] rd_b
);

  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic en;
    assign en = we && (wsel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= '0;
      else if (en) q[g] <= wdata;
    end
  end

  assign rd_a = q[sel_a];
  assign rd_b = q[sel_b];

endmodule

// File: rtl/fx_ticks.sv
module fx_ticks #(
  parameter int TW = 32,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [CW-1:0] add_val,
  output logic [TW-1:0] ticks
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (add_en) cnt_d = cnt_q + TW'(add_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ticks = cnt_q;

  // R4
  tick_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));

  // R4
  tick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int NREG    = 4,
  parameter int TW      = 32,
  parameter int LAT_MEM = 4,
  parameter int LAT_IO  = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   limit,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [4:0]    alu_opc,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  output logic [DW-1:0] alu_st,
  input  logic [DW-1:0] alu_y,
  input  logic [DW-1:0] alu_st_nx,
  input  logic          io_in_valid,
  output logic          io_in_ready,
  input  logic [DW-1:0] io_in_data,
  output logic          io_out_valid,
  input  logic          io_out_ready,
  output logic [DW-1:0] io_out_data,
  output logic          stk_push,
  output logic          stk_pop,
  output logic [AW-1:0] stk_pc_out,
  input  logic [AW-1:0] stk_pc_in,
  output logic [AW-1:0] pc_o,
  output logic          running,
  output logic          halted,
  output logic          error,
  output logic [TW-1:0] tick_count
);

  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(LAT_IO + 1);
  localparam logic [CW-1:0] C_ONE = CW'(1);
  localparam logic [CW-1:0] C_MEM = CW'(LAT_MEM);
  localparam logic [CW-1:0] C_IO  = CW'(LAT_IO);

  seq_state_e     state_q, state_d;
  logic [AW-1:0]  pc_q, pc_d;
  logic [DW-1:0]  ir_q, ir_d;
  logic [DW-1:0]  sr_q, sr_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           iod_q, iod_d;
  logic           err_q, err_d;
  logic [AW:0]    lim_q, lim_d;

  logic [4:0]     opc;
  logic [RW-1:0]  rd, rs;
  logic           imm;
  logic [7:0]     k8;
  logic [DW-1:0]  kx;
  lat_class_e     cls;
  logic           legal;

  logic           rf_we;
  logic [DW-1:0]  rf_wd, ra, rb;
  logic [CW-1:0]  cost;
  logic           in_exec, xfer_in, xfer_out, last, retire;

  fx_decode #(.DW(DW), .RW(RW)) u_dec (
    .ir(ir_q), .opc(opc), .rd(rd), .rs(rs), .imm(imm),
    .k8(k8), .kx(kx), .cls(cls), .legal(legal)
  );

  fx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wsel(rd), .wdata(rf_wd),
    .sel_a(rd), .sel_b(rs), .rd_a(ra), .rd_b(rb)
  );

  // cost and completion of the instruction in execute
  always_comb begin
    unique case (cls)
      CL_MEM:  cost = C_MEM;
      CL_IO:   cost = C_IO;
      default: cost = C_ONE;
    endcase
    in_exec  = (state_q == S_EXEC);
    xfer_in  = in_exec && opc == OP_READ  && !iod_q && io_in_valid;
    xfer_out = in_exec && opc == OP_WRITE && !iod_q && io_out_ready;
    last     = in_exec && (cnt_q == cost - C_ONE) &&
               (cls != CL_IO || iod_q || xfer_in || xfer_out);
    retire   = last && legal;
  end

  fx_ticks #(.TW(TW), .CW(CW)) u_tk (
    .clk(clk), .rst_n(rst_n), .clr(start && !running),
    .add_en(retire), .add_val(cost), .ticks(tick_count)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    sr_d    = sr_q;
    cnt_d   = cnt_q;
    iod_d   = iod_q;
    err_d   = err_q;
    lim_d   = lim_q;
    unique case (state_q)
      S_IDLE, S_STOP: begin
        if (start) begin
          state_d = S_FETCH;
          pc_d    = '0;
          sr_d    = '0;
          err_d   = 1'b0;
          lim_d   = limit;
        end
      end
      S_FETCH: begin
        if ({1'b0, pc_q} >= lim_q) begin
          err_d   = 1'b1;
          state_d = S_STOP;
        end else begin
          state_d = S_LATCH;
        end
      end
      S_LATCH: begin
        ir_d    = mem_rdata;
        pc_d    = pc_q + AW'(1);
        cnt_d   = '0;
        iod_d   = 1'b0;
        state_d = S_EXEC;
      end
      S_EXEC: begin
        if (xfer_in || xfer_out) iod_d = 1'b1;
        if (!legal) begin
          err_d   = 1'b1;
          state_d = S_STOP;
        end else if (!last) begin
          if (cnt_q != cost - C_ONE) cnt_d = cnt_q + C_ONE;
        end else begin
          state_d = (opc == OP_HALT) ? S_STOP : S_FETCH;
          if (opc >= OP_ALU_LO && opc <= OP_CMP) sr_d = alu_st_nx;
          if (opc == OP_PUTST) sr_d = ra;
          if (opc == OP_JMP || opc == OP_CALL ||
              (opc == OP_JLT && sr_q[ST_LT]) ||
              (opc == OP_JEQ && sr_q[ST_EQ]) ||
              (opc == OP_JGT && sr_q[ST_GT]))
            pc_d = k8;
          if (opc == OP_RET) pc_d = stk_pc_in;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register file write port
  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_y;
    if (xfer_in) begin
      rf_we = 1'b1;
      rf_wd = io_in_data;
    end else if (retire) begin
      if (opc == OP_LOAD) begin
        rf_we = 1'b1;
        rf_wd = imm ? kx : mem_rdata;
      end else if (opc >= OP_ALU_LO && opc < OP_CMP) begin
        rf_we = 1'b1;
        rf_wd = alu_y;
      end else if (opc == OP_GETST) begin
        rf_we = 1'b1;
        rf_wd = sr_q;
      end
    end
  end

  // external ports
  always_comb begin
    mem_rd    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = ra;
    if (state_q == S_FETCH && {1'b0, pc_q} < lim_q) begin
      mem_rd = 1'b1;
    end else if (in_exec && legal && opc == OP_LOAD && !imm && cnt_q == cost - CW'(2)) begin
      mem_rd   = 1'b1;
      mem_addr = k8;
    end else if (retire && opc == OP_STORE) begin
      mem_we   = 1'b1;
      mem_addr = k8;
    end
    alu_opc      = opc;
    alu_a        = ra;
    alu_b        = imm ? kx : rb;
    alu_st       = sr_q;
    io_in_ready  = in_exec && opc == OP_READ && !iod_q;
    io_out_valid = in_exec && opc == OP_WRITE && !iod_q;
    io_out_data  = ra;
    stk_push     = retire && opc == OP_CALL;
    stk_pop      = retire && opc == OP_RET;
    stk_pc_out   = pc_q;
    pc_o         = pc_q;
    running      = (state_q != S_IDLE) && (state_q != S_STOP);
    halted       = (state_q == S_STOP);
    error        = err_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      sr_q    <= '0;
      cnt_q   <= '0;
      iod_q   <= 1'b0;
      err_q   <= 1'b0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ir_q    <= ir_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
      iod_q   <= iod_d;
      err_q   <= err_d;
      lim_q   <= lim_d;
    end
  end

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_LATCH |=> pc_q == $past(pc_q) + AW'(1));

  // R5
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !start |=> halted);

  // R12
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> halted);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_out_valid && !io_out_ready |=> io_out_valid && $stable(io_out_data));

  // R11
  stk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_push && stk_pop));

endmodule

// File: tb/sim_fx_ctrl.sv
module sim_fx_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  limit = '0;
  logic [7:0]  mem_addr;
  logic        mem_rd, mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [4:0]  alu_opc;
  logic [15:0] alu_a, alu_b, alu_st, alu_y, alu_st_nx;
  logic        io_in_valid = 1'b1;
  logic        io_in_ready;
  logic [15:0] io_in_data = '0;
  logic        io_out_valid;
  logic        io_out_ready = 1'b1;
  logic [15:0] io_out_data;
  logic        stk_push, stk_pop;
  logic [7:0]  stk_pc_out, stk_pc_in;
  logic [7:0]  pc_o;
  logic        running, halted, error;
  logic [31:0] tick_count;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  logic [15:0] mem [256];
  logic [7:0]  stk [16];
  int          ssp = 0;
  logic [15:0] exp_q[$];
  logic [15:0] prog[$];

  always #10 clk = ~clk;

  fx_ctrl u0 (.*);

  // synchronous memory model, one cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  // stack engine model
  assign stk_pc_in = (ssp > 0) ? stk[ssp-1] : 8'h00;
  always @(posedge clk) begin
    if (stk_push) begin stk[ssp] <= stk_pc_out; ssp <= ssp + 1; end
    if (stk_pop && ssp > 0) ssp <= ssp - 1;
  end

  // ALU model (opcode numbering as listed in the requirements)
  always_comb begin
    logic [16:0] t;
    alu_y = alu_a;
    alu_st_nx = alu_st;
    t = '0;
    case (alu_opc)
      5'd2:  begin t = {1'b0, alu_a} + {1'b0, alu_b}; alu_y = t[15:0]; alu_st_nx[0] = t[16]; end
      5'd3:  begin t = {1'b0, alu_a} + {1'b0, alu_b} + {16'h0, alu_st[0]}; alu_y = t[15:0]; alu_st_nx[0] = t[16]; end
      5'd4:  begin alu_y = alu_a - alu_b; alu_st_nx[0] = (alu_a < alu_b); end
      5'd6:  alu_y = alu_a & alu_b;
      5'd7:  alu_y = alu_a ^ alu_b;
      5'd8:  alu_y = ~alu_a;
      5'd9:  begin alu_y = alu_a << 1; alu_st_nx[0] = alu_a[15]; end
      5'd11: begin alu_y = alu_a >> 1; alu_st_nx[0] = alu_a[0]; end
      5'd13: begin
        alu_st_nx[3] = ($signed(alu_a) <  $signed(alu_b));
        alu_st_nx[2] = (alu_a == alu_b);
        alu_st_nx[1] = ($signed(alu_a) >  $signed(alu_b));
      end
      default: ;
    endcase
  end

  function automatic logic [15:0] enck(input int op, input int rd, input int i, input int k);
    return {5'(op), 2'(rd), 1'(i), 8'(k)};
  endfunction

  function automatic logic [15:0] encr(input int op, input int rd, input int rs);
    return {5'(op), 2'(rd), 1'b0, 2'(rs), 6'b0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  // scoreboard monitor on the output port
  always @(negedge clk) begin
    if (rst_n && io_out_valid && io_out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected output: actual=%h expected=none", io_out_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (io_out_data !== e) begin
          errors++;
          $display("FAIL R10 output data: actual=%h expected=%h", io_out_data, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  task automatic run_prog(input int lim);
    for (int a = 0; a < 256; a++) mem[a] = 16'h0000;
    for (int a = 0; a < prog.size(); a++) mem[a] = prog[a];
    @(negedge clk);
    limit = 9'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int n = 0;
      while (!halted && n < 3000) begin
        @(negedge clk);
        n++;
      end
    end
    chk("R7", "halted after run", 32'(halted), 32'd1);
    chk("R10", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7", "reset halted", 32'(halted), 32'd0);
    chk("R12", "reset error", 32'(error), 32'd0);
    chk("R4", "reset ticks", tick_count, 32'd0);
    chk("R2", "reset pc", 32'(pc_o), 32'd0);
    chk("R7", "reset running", 32'(running), 32'd0);

    // read, negative immediate, register add, write
    prog = '{enck(22,0,0,0), enck(0,1,1,8'hFE), encr(2,0,1), enck(23,0,0,0), enck(24,0,0,0)};
    io_in_data = 16'd10;
    expect_out(16'd8);                                  // R9 R1 R3 add of sign-extended -2
    run_prog(5);
    chk("R4", "ticks read/loadi/add/write/halt", tick_count, 32'd59);
    chk("R2", "pc after halt", 32'(pc_o), 32'd5);
    chk("R12", "no error", 32'(error), 32'd0);

    // call/return with memory traffic and a stalled output
    prog = '{enck(22,0,0,0), enck(20,0,1,5), enck(0,0,0,8), enck(23,0,0,0), enck(24,0,0,0),
             enck(2,0,1,5), enck(1,0,1,8), enck(21,0,0,0), enck(25,0,0,0)};
    io_in_data = 16'd7;
    io_out_ready = 1'b0;
    expect_out(16'd12);                                 // R11 R5 R3
    fork
      begin repeat (150) @(negedge clk); io_out_ready = 1'b1; end
    join_none
    run_prog(9);
    chk("R5", "stored word", 32'(mem[8]), 32'd12);
    chk("R4", "ticks unchanged by stall", tick_count, 32'd74);
    chk("R11", "pc after return path", 32'(pc_o), 32'd5);
    chk("R11", "stack balanced", 32'(ssp), 32'd0);

    // compares, jumps, status moves, shift, store/load, xor
    prog = '{enck(0,0,1,5), enck(13,0,1,5), enck(18,0,1,4), enck(24,0,0,0),
             enck(13,0,1,7), enck(19,0,1,3), enck(17,0,1,8), enck(24,0,0,0),
             enck(14,1,0,0), enck(23,1,0,0), enck(0,2,1,8'hFF), enck(15,2,0,0),
             enck(14,3,0,0), enck(23,3,0,0), enck(11,2,0,0), enck(1,2,1,40),
             enck(0,3,0,40), enck(23,3,0,0), enck(0,0,1,8'h80), encr(7,0,2),
             enck(23,0,0,0), enck(16,0,1,23), enck(24,0,0,0), enck(25,0,0,0),
             enck(24,0,0,0)};
    expect_out(16'h0008);                               // R8 getstat after less compare, R6
    expect_out(16'hFFFF);                               // R8 putstat then getstat
    expect_out(16'h7FFF);                               // R9 shift, R5 R3 memory round trip
    expect_out(16'h807F);                               // R1 sign extension and rs field
    io_in_data = 16'd0;
    run_prog(25);
    chk("R5", "stored shifted word", 32'(mem[40]), 32'h7FFF);
    chk("R4", "ticks mixed program", tick_count, 32'd136);
    chk("R6", "pc after jump and noop", 32'(pc_o), 32'd25);
    chk("R7", "noop path no error", 32'(error), 32'd0);

    // illegal opcode
    prog = '{enck(25,0,0,0), 16'hD000, enck(24,0,0,0)};
    run_prog(3);
    chk("R12", "illegal opcode error", 32'(error), 32'd1);
    chk("R12", "illegal adds no ticks", tick_count, 32'd1);
    chk("R12", "pc after illegal", 32'(pc_o), 32'd2);

    // fetch runs past the limit
    prog = '{enck(25,0,0,0), enck(25,0,0,0)};
    run_prog(2);
    chk("R12", "limit overrun error", 32'(error), 32'd1);
    chk("R4", "ticks before overrun", tick_count, 32'd2);
    chk("R2", "pc stops at limit", 32'(pc_o), 32'd2);

    finish_run();
  end

endmodule